// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory is ready for normal traffic. While it runs it keeps clock enable high, keeps the data mask high, and drives no-operation commands. This lasts for a stabilization pause whose length is a cycle-count parameter: 200 microseconds or more, converted to cycles at the system clock. After the pause it steps through a fixed bring-up order. First a precharge of every bank, then a mode register load, then a programmable number of dummy auto refreshes (two or more). Each command is followed by the wait that the device needs before the next one.

When the last refresh wait has run out, the sequencer raises a ready flag, drops the data mask and keeps driving no-operation commands. From then on a normal memory controller may take over the pins. The mode word is an input and is copied onto the address pins when the mode register load is issued. The two test-mode bits are forced to zero so that the device always stays in normal operation. A synchronous reset at any time restarts the whole sequence from the pause.

Commands are coded on {cs_n, ras_n, cas_n, we_n}: no-op 0111, precharge 0010, mode load 0000, auto refresh 0001. All outputs are registered.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high and in the cycle that follows it, the pins carry the no-op code 0111, clock enable is 1, every data mask bit is 1, address and bank are 0, and the ready flag is 0.
- R2: After reset is released, the outputs hold no-op with all data mask bits at 1 following each of the first PAUSE_CYCLES-1 rising edges. The data mask stays all ones for as long as the ready flag is 0.
- R3: The precharge-all command (code 0010) appears after the PAUSE_CYCLES-th rising edge with reset low. Address bit 10 is 1, every other address bit is 0, and bank is 0.
- R4: The mode register load (code 0000) appears TRP_CYCLES edges after the precharge. Its address is the mode word sampled at that edge, with bit 10 driven 0 and bank 0.
- R5: During the mode register load, address bits 8 and 7 (the test-mode field) are driven 0 whatever the mode word holds. Bits 9, 6 to 4, 3 and 2 to 0 pass through unchanged.
- R6: The first auto refresh (code 0001) appears TMRD_CYCLES edges after the mode register load.
- R7: Exactly REF_COUNT auto refresh commands are issued, each TRC_CYCLES edges after the previous one.
- R8: The ready flag rises TRC_CYCLES edges after the last refresh. In that same cycle the data mask goes to all zeros. After that the flag stays 1 and the pins stay at no-op.
- R9: Every command lasts one cycle. Every cycle that carries no command carries the no-op code with address and bank at 0.
- R10: Clock enable is 1 in every cycle.
- R11: A reset asserted in the middle of the sequence brings the outputs back to the R1 state on the next edge. After release, the full sequence runs again from the start of the pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, restarts the sequence |
| mode_word | input | ADDR_W | Value to load into the device mode register |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BA_W | Bank select |
| sd_cke | output | 1 | Clock enable, held high |
| sd_dqm | output | DQM_W | Data mask, high until ready |
| init_done | output | 1 | Ready flag, high once initialization is complete |

## Verification
The bound checker watches the relationships that hold in every cycle:
- clock enable is always high;
- the data mask is set whenever the ready flag is low;
- precharge always carries bit 10, and the mode load never carries the test-mode bits;
- each command is followed by a no-op, and idle cycles carry a zero address;
- the ready flag never falls, and the cycle after reset is quiet.

The exact cycle of each command, the refresh count, the spacing of the waits and the restart after a mid-sequence reset can only be shown by the bench scenarios. The bench builds a cycle-by-cycle expected trace from the parameters and compares the pins against it.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command code on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE    = 3'd0,
    ST_WAIT_RP  = 3'd1,
    ST_WAIT_MRD = 3'd2,
    ST_WAIT_RC  = 3'd3,
    ST_READY    = 3'd4
  } init_state_e;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int          CNT_W     = 16,
  parameter int unsigned RESET_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  // Down counter: the reset value times the pause, reloads time each later wait
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(RESET_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TRP_CYCLES  = 3,
  parameter int TMRD_CYCLES = 2,
  parameter int TRC_CYCLES  = 9,
  parameter int REF_COUNT   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output sdram_cmd_e       issue,
  output logic             ready_next
);

  localparam int RC_W = (REF_COUNT > 1) ? $clog2(REF_COUNT) : 1;

  init_state_e     state_q, state_d;
  logic [RC_W-1:0] refs_left_q, refs_left_d;

  always_comb begin
    state_d     = state_q;
    refs_left_d = refs_left_q;
    issue       = CMD_NOP;
    load        = 1'b0;
    load_val    = '0;
    ready_next  = (state_q == ST_READY);
    case (state_q)
      ST_PAUSE: begin
        if (expired) begin
          issue    = CMD_PRE;
          load     = 1'b1;
          load_val = CNT_W'(TRP_CYCLES - 1);
          state_d  = ST_WAIT_RP;
        end
      end
      ST_WAIT_RP: begin
        if (expired) begin
          issue    = CMD_MRS;
          load     = 1'b1;
          load_val = CNT_W'(TMRD_CYCLES - 1);
          state_d  = ST_WAIT_MRD;
        end
      end
      ST_WAIT_MRD: begin
        if (expired) begin
          issue       = CMD_REF;
          load        = 1'b1;
          load_val    = CNT_W'(TRC_CYCLES - 1);
          refs_left_d = RC_W'(REF_COUNT - 1);
          state_d     = ST_WAIT_RC;
        end
      end
      ST_WAIT_RC: begin
        if (expired) begin
          if (refs_left_q != '0) begin
            issue       = CMD_REF;
            load        = 1'b1;
            load_val    = CNT_W'(TRC_CYCLES - 1);
            refs_left_d = refs_left_q - RC_W'(1);
          end else begin
            state_d    = ST_READY;
            ready_next = 1'b1;
          end
        end
      end
      ST_READY: begin
        state_d = ST_READY;
      end
      default: begin
        state_d = ST_PAUSE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_PAUSE;
      refs_left_q <= '0;
    end else begin
      state_q     <= state_d;
      refs_left_q <= refs_left_d;
    end
  end

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2,
  parameter int DQM_W    = 2,
  parameter int AP_BIT   = 10,
  parameter int TEST_LSB = 7,
  parameter int TEST_MSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  sdram_cmd_e        issue,
  input  logic              ready_next,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic              done
);

  localparam logic [ADDR_W-1:0] PRE_ADDR  = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] TEST_BITS = (ADDR_W'(1) << TEST_LSB) | (ADDR_W'(1) << TEST_MSB);
  localparam logic [ADDR_W-1:0] MRS_KEEP  = ~(PRE_ADDR | TEST_BITS);

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    case (issue)
      CMD_PRE: addr_d = PRE_ADDR;
      CMD_MRS: addr_d = mode_word & MRS_KEEP;
      default: addr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      addr <= '0;
      ba   <= '0;
      cke  <= 1'b1;
      dqm  <= '1;
      done <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= issue;
      addr <= addr_d;
      ba   <= '0;
      cke  <= 1'b1;
      dqm  <= ready_next ? '0 : '1;
      done <= ready_next;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2,
  parameter int DQM_W        = 2,
  parameter int PAUSE_CYCLES = 25000,
  parameter int TRP_CYCLES   = 3,
  parameter int TMRD_CYCLES  = 2,
  parameter int TRC_CYCLES   = 9,
  parameter int REF_COUNT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);

  localparam int MAX_A = (TRP_CYCLES > TMRD_CYCLES) ? TRP_CYCLES : TMRD_CYCLES;
  localparam int MAX_B = (TRC_CYCLES > MAX_A) ? TRC_CYCLES : MAX_A;
  localparam int MAX_W = (PAUSE_CYCLES > MAX_B) ? PAUSE_CYCLES : MAX_B;
  localparam int CNT_W = $clog2(MAX_W + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  sdram_cmd_e       issue;
  logic             ready_next;

  sdram_init_timer #(
    .CNT_W     (CNT_W),
    .RESET_VAL (PAUSE_CYCLES - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sdram_init_fsm #(
    .CNT_W       (CNT_W),
    .TRP_CYCLES  (TRP_CYCLES),
    .TMRD_CYCLES (TMRD_CYCLES),
    .TRC_CYCLES  (TRC_CYCLES),
    .REF_COUNT   (REF_COUNT)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .expired    (tmr_expired),
    .load       (tmr_load),
    .load_val   (tmr_val),
    .issue      (issue),
    .ready_next (ready_next)
  );

  sdram_init_pins #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .DQM_W  (DQM_W)
  ) u_pins (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .ready_next (ready_next),
    .mode_word  (mode_word),
    .cs_n       (sd_cs_n),
    .ras_n      (sd_ras_n),
    .cas_n      (sd_cas_n),
    .we_n       (sd_we_n),
    .addr       (sd_addr),
    .ba         (sd_ba),
    .cke        (sd_cke),
    .dqm        (sd_dqm),
    .done       (init_done)
  );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W      = 12,
  parameter int BA_W        = 2,
  parameter int DQM_W       = 2,
  parameter int TRP_CYCLES  = 3,
  parameter int TMRD_CYCLES = 2,
  parameter int TRC_CYCLES  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BA_W-1:0]   sd_ba,
  input logic              sd_cke,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              init_done
);

  localparam bit GAPS_OVER_ONE = (TRP_CYCLES > 1) && (TMRD_CYCLES > 1) && (TRC_CYCLES > 1);

  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  AST_CKE_HIGH: assert property (@(posedge clk) disable iff (rst) sd_cke); // R10
  AST_MASK_UNTIL_READY: assert property (@(posedge clk) disable iff (rst) !init_done |-> (&sd_dqm)); // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst) (cmd == 4'b0010) |-> sd_addr[10]); // R3
  AST_MRS_NO_TEST: assert property (@(posedge clk) disable iff (rst) (cmd == 4'b0000) |-> (sd_addr[8:7] == 2'b00 && !sd_addr[10])); // R5
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst) init_done |=> init_done); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst) init_done |-> (cmd == 4'b0111 && sd_dqm == '0)); // R8
  AST_ONE_CYCLE_CMD: assert property (@(posedge clk) disable iff (rst) (GAPS_OVER_ONE && cmd != 4'b0111) |=> (cmd == 4'b0111)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) (cmd == 4'b0111) |-> (sd_addr == '0 && sd_ba == '0)); // R9
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (cmd == 4'b0111 && !init_done && (&sd_dqm))); // R11

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W      (ADDR_W),
  .BA_W        (BA_W),
  .DQM_W       (DQM_W),
  .TRP_CYCLES  (TRP_CYCLES),
  .TMRD_CYCLES (TMRD_CYCLES),
  .TRC_CYCLES  (TRC_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_addr   (sd_addr),
  .sd_ba     (sd_ba),
  .sd_cke    (sd_cke),
  .sd_dqm    (sd_dqm),
  .init_done (init_done)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

  localparam int P    = 40;
  localparam int TRP  = 3;
  localparam int TMRD = 2;
  localparam int TRC  = 9;
  localparam int NREF = 3;
  localparam int T_MRS  = P + TRP;
  localparam int T_REF0 = T_MRS + TMRD;
  localparam int T_DONE = T_REF0 + NREF * TRC;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [11:0] addr;
    logic        done;
    logic [1:0]  dqm;
    logic        cke;
    logic [7:0]  req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mode_word = '0;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, init_done;
  logic [11:0] sd_addr;
  logic [1:0]  sd_ba, sd_dqm;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  sdram_init_seq #(
    .ADDR_W (12), .BA_W (2), .DQM_W (2),
    .PAUSE_CYCLES (P), .TRP_CYCLES (TRP), .TMRD_CYCLES (TMRD),
    .TRC_CYCLES (TRC), .REF_COUNT (NREF)
  ) uut (
    .clk (clk), .rst (rst), .mode_word (mode_word),
    .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n),
    .sd_addr (sd_addr), .sd_ba (sd_ba), .sd_cke (sd_cke), .sd_dqm (sd_dqm),
    .init_done (init_done)
  );

  // Expected pins after the n-th rising edge with reset low
  function automatic item_t expect_at(int n, logic [11:0] mw);
    item_t e;
    e.cmd  = 4'b0111;
    e.addr = '0;
    e.done = 1'b0;
    e.dqm  = 2'b11;
    e.cke  = 1'b1;
    e.req  = (n < P) ? 8'd2 : 8'd9;               // R2 pause, R9 idle gaps
    if (n == P) begin                              // R3
      e.cmd = 4'b0010; e.addr = 12'h400; e.req = 8'd3;
    end else if (n == T_MRS) begin                 // R4, R5: bits 10, 8, 7 cleared
      e.cmd = 4'b0000; e.addr = mw & 12'hA7F; e.req = 8'd5;
    end else if (n == T_REF0) begin                // R6
      e.cmd = 4'b0001; e.req = 8'd6;
    end else if (n > T_REF0 && n < T_DONE && ((n - T_REF0) % TRC) == 0) begin
      e.cmd = 4'b0001; e.req = 8'd7;               // R7
    end else if (n >= T_DONE) begin                // R8
      e.done = 1'b1; e.dqm = 2'b00; e.req = 8'd8;
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver: releases reset and fills the scoreboard for the cycles to come
  task automatic run_seq(input logic [11:0] mw, input int stop);
    @(negedge clk);
    mode_word = mw;
    rst = 1'b0;
    @(posedge clk);
    #1;
    for (int n = 1; n <= stop; n++) exp_q.push_back(expect_at(n, mw));
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops one expected item per cycle and compares the pins
  always @(negedge clk) begin : monitor
    item_t e;
    item_t g;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      g.cmd  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      g.addr = sd_addr;
      g.done = init_done;
      g.dqm  = sd_dqm;
      g.cke  = sd_cke;
      g.req  = e.req;
      checks++;
      if (g != e || sd_ba != 2'b00) begin
        errors++;
        $display("FAIL R%0d actual=%h ba=%0d expected=%h", e.req, g, sd_ba, e);
      end
      if (sd_cke !== 1'b1) begin
        errors++;
        $display("FAIL R10 actual=%0b expected=1", sd_cke);
      end
    end
  end

  task automatic check_quiet(input string req);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, req, {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    check(init_done == 1'b0 && sd_dqm == 2'b11 && sd_cke == 1'b1, req, {init_done, sd_dqm, sd_cke}, 4'b0111);
    check(sd_addr == '0 && sd_ba == '0, req, {sd_ba, sd_addr}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R1");                              // state while in reset
    // Full run: mode word with A10 and test bits set, to see them cleared (R4, R5)
    run_seq(12'hFB5, T_DONE + 6);
    // Ready stays high with no-ops (R8)
    repeat (4) @(negedge clk);
    check(init_done == 1'b1 && sd_dqm == 2'b00, "R8", {init_done, sd_dqm}, 3'b100);
    // Reset in the middle of the refresh waits (R11)
    @(negedge clk); rst = 1'b1;
    run_seq_partial();
    // Second full run after the restart with a different mode word (R11)
    run_seq(12'h232, T_DONE + 3);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic run_seq_partial();
    @(negedge clk);
    check_quiet("R1");
    run_seq(12'h0A5, T_REF0 + 4);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check_quiet("R11");
    @(negedge clk);
    check_quiet("R11");
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=%0b expected=1", init_done);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule